// File: doc/BRIEF.md
# Character Dot-Row Fetch with Cursor Overlay

This block turns an 8-bit character code and a pixel row index (0 to 7) into the five dot bits that the display scanner shifts out for that row. Codes whose upper four bits are all zero are user-defined glyphs. Their patterns live in a 128-entry by 5-bit pattern store inside the block, and the host fills that store through a simple write port. Every other code is resolved by an external font ROM. The block drives the ROM's address through a lookup port and takes the ROM's registered answer one clock later.

On top of the glyph, the block draws the cursor for the cell that holds it. The bottom row (row 7) is combined by OR with a full-width underline. In blink mode, while the blink phase is active, the whole cell is lit. Both kinds of cursor are suppressed while the host's address counter points into pattern memory rather than display memory.

Both lookup paths have the same latency. Inputs sampled at one rising edge give `dots_o` for the whole of the following cycle.

Top module: `glyph_row_fetch`

## Requirements
- R1: When `code_i[7:4]` is 0, `dots_o` shows the stored user pattern, and `rom_dots_i` has no effect on it. Stored bit n appears on `dots_o[n]`, with bit 4 as the leftmost dot and 1 meaning lit.
- R2: The user pattern address is `{code_i[3:0], row_i}`. This gives 16 user glyphs of 8 rows each, all independently addressable.
- R3: For a code with `code_i[7:4]` nonzero, `rom_code_o` and `rom_row_o` carry the code and row in the same cycle. `dots_o` in the next cycle equals `rom_dots_i` as returned by the ROM in that cycle.
- R4: On both paths, inputs sampled at a rising edge determine `dots_o` from that edge until the next one.
- R5: A write with `wr_en_i`=1 stores `wr_data_i` at `wr_addr_i` at the rising edge. A read of the same address sampled at that same edge returns the previous content, and a later read returns the new content.
- R6: When `row_i`=7, `cursor_en_i`=1 and `cursor_cell_i`=1, the dots are ORed with the underline, so `dots_o`=5'b11111. Rows 0 to 6 of the cursor cell show the plain glyph.
- R7: When `blink_en_i`=1, `blink_phase_i`=1 and `cursor_cell_i`=1, `dots_o`=5'b11111 on every row. With `blink_phase_i`=0 the plain glyph is shown.
- R8: While `ac_in_pattern_i`=1, neither the underline nor the blink fill is applied, and the plain glyph is shown.
- R9: While `rst_n` is low, and in the cycle after it is released, `dots_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_i | input | 8 | Character code of the cell being scanned |
| row_i | input | 3 | Pixel row within the cell, 0 at the top |
| cursor_en_i | input | 1 | Underline cursor enable |
| blink_en_i | input | 1 | Blink cursor enable |
| blink_phase_i | input | 1 | Blink phase, 1 while the cell is lit solid |
| cursor_cell_i | input | 1 | The cell being scanned is the cursor position |
| ac_in_pattern_i | input | 1 | Address counter points into pattern memory; cursor suppressed |
| wr_en_i | input | 1 | User pattern write strobe |
| wr_addr_i | input | 7 | User pattern write address {glyph, row} |
| wr_data_i | input | 5 | User pattern write data |
| rom_code_o | output | 8 | Font ROM lookup code |
| rom_row_o | output | 3 | Font ROM lookup row |
| rom_dots_i | input | 5 | Font ROM answer, valid one cycle after lookup |
| dots_o | output | 5 | Dot bits for the row, bit 4 leftmost |

## Verification
A corrupted path-select flag would show up in the very next cycle as a ROM row appearing where a user glyph was expected, or the reverse. A bad pattern-store address would show a neighbouring glyph row. The exhaustive sweep over all 128 user entries and all 1920 ROM code/row pairs detects either kind on the first mismatching pair. Errors in the stored cursor flags show at most one cycle later, as a lit or missing underline or solid cell. Separate sweeps over the cursor, blink and inhibit combinations on both paths check this.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int CODE_W_DEF     = 8;
  localparam int ROW_W_DEF      = 3;
  localparam int DOT_W_DEF      = 5;
  localparam int USER_IDX_W_DEF = 4;

  // Flags captured alongside the lookup so they line up with the answer.
  typedef struct packed {
    logic sel_user;
    logic underline;
    logic solid;
  } stage_t;
endpackage

// File: rtl/glyph_user_ram.sv
module glyph_user_ram #(
  parameter int ADDR_W = 7,
  parameter int DOT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DOT_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DOT_W-1:0]  rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DOT_W-1:0] mem [DEPTH];
  logic [DOT_W-1:0] rd_pre;

  // Read the array before the write lands: old data on a same-edge clash.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_pre = mem[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_pre;
  end
endmodule

// File: rtl/glyph_compose.sv
module glyph_compose #(
  parameter int DOT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  glyph_pkg::stage_t stage_d,
  input  logic [DOT_W-1:0] ram_dots,
  input  logic [DOT_W-1:0] rom_dots,
  output glyph_pkg::stage_t stage_q,
  output logic [DOT_W-1:0] dots
);
  logic [DOT_W-1:0] base;

  function automatic logic [DOT_W-1:0] overlay(
    input logic [DOT_W-1:0] glyph,
    input logic             underline,
    input logic             solid
  );
    logic [DOT_W-1:0] r;
    r = glyph | {DOT_W{underline}};
    if (solid) r = '1;
    return r;
  endfunction

  // Reset picks the user path with a cleared read register: blank output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '{sel_user: 1'b1, underline: 1'b0, solid: 1'b0};
    else        stage_q <= stage_d;
  end

  assign base = stage_q.sel_user ? ram_dots : rom_dots;
  assign dots = overlay(base, stage_q.underline, stage_q.solid);
endmodule

// File: rtl/glyph_row_fetch.sv
module glyph_row_fetch #(
  parameter int CODE_W     = glyph_pkg::CODE_W_DEF,
  parameter int ROW_W      = glyph_pkg::ROW_W_DEF,
  parameter int DOT_W      = glyph_pkg::DOT_W_DEF,
  parameter int USER_IDX_W = glyph_pkg::USER_IDX_W_DEF,
  localparam int UADDR_W   = USER_IDX_W + ROW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic               cursor_en_i,
  input  logic               blink_en_i,
  input  logic               blink_phase_i,
  input  logic               cursor_cell_i,
  input  logic               ac_in_pattern_i,
  input  logic               wr_en_i,
  input  logic [UADDR_W-1:0] wr_addr_i,
  input  logic [DOT_W-1:0]   wr_data_i,
  output logic [CODE_W-1:0]  rom_code_o,
  output logic [ROW_W-1:0]   rom_row_o,
  input  logic [DOT_W-1:0]   rom_dots_i,
  output logic [DOT_W-1:0]   dots_o
);
  localparam logic [ROW_W-1:0] CURSOR_ROW = {ROW_W{1'b1}};

  function automatic logic is_user_code(input logic [CODE_W-1:0] c);
    return c[CODE_W-1:USER_IDX_W] == '0;
  endfunction

  function automatic logic [UADDR_W-1:0] user_addr(
    input logic [CODE_W-1:0] c,
    input logic [ROW_W-1:0]  r
  );
    return {c[USER_IDX_W-1:0], r};
  endfunction

  // Named internal events, observed by the assertions below.
  logic               user_hit;
  logic               cursor_ok;
  logic               underline_hit;
  logic               solid_hit;
  logic [UADDR_W-1:0] rd_addr;
  logic [DOT_W-1:0]   ram_rd;
  logic               primed;
  glyph_pkg::stage_t  stage_d;
  glyph_pkg::stage_t  stage_q;

  assign user_hit      = is_user_code(code_i);
  assign rd_addr       = user_addr(code_i, row_i);
  assign cursor_ok     = cursor_cell_i & ~ac_in_pattern_i;
  assign underline_hit = cursor_en_i & cursor_ok & (row_i == CURSOR_ROW);
  assign solid_hit     = blink_en_i & blink_phase_i & cursor_ok;

  assign stage_d = '{sel_user: user_hit, underline: underline_hit, solid: solid_hit};

  assign rom_code_o = code_i;
  assign rom_row_o  = row_i;

  glyph_user_ram #(.ADDR_W(UADDR_W), .DOT_W(DOT_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en_i),
    .waddr (wr_addr_i),
    .wdata (wr_data_i),
    .raddr (rd_addr),
    .rdata (ram_rd)
  );

  glyph_compose #(.DOT_W(DOT_W)) u_comp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stage_d  (stage_d),
    .ram_dots (ram_rd),
    .rom_dots (rom_dots_i),
    .stage_q  (stage_q),
    .dots     (dots_o)
  );

  // Set one edge after reset release, so $past never sees reset-time inputs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_user_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(is_user_code(code_i) && !cursor_cell_i) |-> dots_o == ram_rd);

  assert_rom_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!is_user_code(code_i) && !cursor_cell_i) |-> dots_o == rom_dots_i);

  assert_underline_R6: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(cursor_en_i && cursor_cell_i && !ac_in_pattern_i && row_i == CURSOR_ROW)
      |-> dots_o == {DOT_W{1'b1}});

  assert_blink_solid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(blink_en_i && blink_phase_i && cursor_cell_i && !ac_in_pattern_i)
      |-> dots_o == {DOT_W{1'b1}});

  assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(ac_in_pattern_i && !is_user_code(code_i)) |-> dots_o == rom_dots_i);

  assert_reset_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> dots_o == '0);
endmodule

// File: tb/sim_glyph_row_fetch.sv
module sim_glyph_row_fetch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] code = '0;
  logic [2:0] row = '0;
  logic       cen = 0, ben = 0, bph = 0, ccell = 0, acp = 0;
  logic       wen = 0;
  logic [6:0] waddr = '0;
  logic [4:0] wdata = '0;
  logic [7:0] rom_code;
  logic [2:0] rom_row;
  logic [4:0] rom_q = '0;
  logic [4:0] dots;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  glyph_row_fetch u0 (
    .clk(clk), .rst_n(rst_n), .code_i(code), .row_i(row),
    .cursor_en_i(cen), .blink_en_i(ben), .blink_phase_i(bph),
    .cursor_cell_i(ccell), .ac_in_pattern_i(acp),
    .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata),
    .rom_code_o(rom_code), .rom_row_o(rom_row), .rom_dots_i(rom_q),
    .dots_o(dots)
  );

  function automatic logic [4:0] font(input int c, input int r);
    return 5'((c * 3 + r * 11 + 7) % 32);
  endfunction

  function automatic logic [4:0] upat(input int a);
    return 5'((a * 13 + 5) % 32);
  endfunction

  // Registered font ROM model: answer one cycle after the lookup.
  always_ff @(posedge clk) rom_q <= font(int'(rom_code), int'(rom_row));

  task automatic check(input logic [4:0] exp, input string tag);
    total++;
    if (dots !== exp) begin
      bad++;
      $display("FAIL %s code=%0h row=%0d got=%b exp=%b", tag, code, row, dots, exp);
    end
  endtask

  task automatic look(input int c, input int r, input logic ce, input logic be,
                      input logic bp, input logic cc, input logic ap,
                      input logic [4:0] exp, input string tag);
    @(negedge clk);
    code = 8'(c); row = 3'(r); cen = ce; ben = be; bph = bp; ccell = cc; acp = ap;
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic wr(input int a, input logic [4:0] d);
    @(negedge clk);
    wen = 1'b1; waddr = 7'(a); wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: blank during reset and in the first cycle after release.
    repeat (3) @(negedge clk);
    check(5'b0, "R9 in reset");
    code = 8'h41; row = 3'd2;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(5'b0, "R9 after release");

    // R5, R2: fill all 128 user entries.
    for (int a = 0; a < 128; a++) wr(a, upat(a));

    // R1, R2, R4: every user glyph row, no cursor.
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 8; r++)
        look(c, r, 0, 0, 0, 0, 0, upat(c * 8 + r), "R1 R2 user sweep");

    // R3, R4: every ROM code and row.
    for (int c = 16; c < 256; c++)
      for (int r = 0; r < 8; r++)
        look(c, r, 0, 0, 0, 0, 0, font(c, r), "R3 rom sweep");

    // R6: underline on row 7 only, on both paths.
    for (int r = 0; r < 8; r++) begin
      look(5, r, 1, 0, 0, 1, 0, (r == 7) ? 5'h1f : upat(40 + r), "R6 user cursor");
      look(8'h9c, r, 1, 0, 0, 1, 0, (r == 7) ? 5'h1f : font(8'h9c, r), "R6 rom cursor");
      look(8'h9c, r, 1, 0, 0, 0, 0, font(8'h9c, r), "R6 not cursor cell");
    end

    // R7: blink fills every row while the phase is active.
    for (int r = 0; r < 8; r++) begin
      look(3, r, 0, 1, 1, 1, 0, 5'h1f, "R7 blink on user");
      look(8'h52, r, 0, 1, 1, 1, 0, 5'h1f, "R7 blink on rom");
      look(8'h52, r, 0, 1, 0, 1, 0, font(8'h52, r), "R7 blink phase off");
      look(8'h52, r, 0, 0, 1, 1, 0, font(8'h52, r), "R7 blink disabled");
    end

    // R8: pattern-memory addressing suppresses both cursor forms.
    for (int r = 0; r < 8; r++) begin
      look(8'h77, r, 1, 1, 1, 1, 1, font(8'h77, r), "R8 inhibit rom");
      look(9, r, 1, 1, 1, 1, 1, upat(72 + r), "R8 inhibit user");
    end

    // R5: read at the write edge returns old data, later reads the new.
    @(negedge clk);
    code = 8'h0b; row = 3'd4; cen = 0; ben = 0; bph = 0; ccell = 0; acp = 0;
    wen = 1'b1; waddr = 7'(8'h0b * 8 + 4); wdata = 5'b10001;
    @(negedge clk);
    wen = 1'b0;
    check(upat(8'h0b * 8 + 4), "R5 same-edge old data");
    @(negedge clk);
    check(5'b10001, "R5 new data visible");

    // R1: bit 4 is the leftmost dot, single-dot patterns pass unchanged.
    for (int b = 0; b < 5; b++) begin
      wr(6 * 8 + 1, 5'(1 << b));
      look(6, 1, 0, 0, 0, 0, 0, 5'(1 << b), "R1 dot position");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule